// File: doc/BRIEF.md
# Frame-Gated Serializer Clock Switch

This block chooses which clock feeds a downstream serializer's pixel clock pin. Out of reset it passes through a free-running reference oscillator clock. That lets the serial link's control channel come up and program the camera before the camera has produced any pixel clock of its own.

The block counts camera frame-sync pulses in the reference domain. When a set number of them has been seen, the camera's internal clocking is taken to have settled. The output then moves, once and for good, to the camera pixel clock divided by two.

Counting frames rather than pixel clocks keeps the readiness counter only a few bits wide. The handover between the two clocks is glitch-free. Each clock's gate closes on that clock's own falling edge, and it closes before the other clock's gate opens. A status output reports that the switch has completed.

Top module: `frame_gated_clk_switch`

## Requirements
- R1: While reset is held and after its release, until the switch, `clk_out` follows `ref_clk` (high while `ref_clk` is high, low while it is low) and `locked` is 0.
- R2: Before the switch, `clk_out` keeps following `ref_clk` whether or not `cam_pclk` toggles.
- R3: Fewer than `SYNC_PULSES` rising edges on `frame_sync` (default 4) leave `locked` at 0 and the reference clock selected.
- R4: The `SYNC_PULSES`-th rising edge of `frame_sync` after reset causes `locked` to rise within a few reference and pixel clock cycles.
- R5: Once `locked` is 1, `clk_out` has a period of exactly two `cam_pclk` periods.
- R6: Once `locked` is 1 it stays 1 until reset, and further `frame_sync` activity changes neither `locked` nor the output period.
- R7: No high or low phase of `clk_out` is shorter than the shorter of the half-periods of `ref_clk` and the halved pixel clock, including during the handover.
- R8: The reference gate and the pixel-clock gate are never open at the same time, and the frame counter never passes `SYNC_PULSES`.
- R9: Asserting reset again returns the output to the reference clock, clears `locked`, and restarts the frame count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference oscillator clock |
| cam_pclk | input | 1 | Camera pixel clock; may be idle until the camera is initialised |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Camera frame-sync signal, asynchronous to `ref_clk` |
| clk_out | output | 1 | Selected clock for the serializer |
| locked | output | 1 | 1 once the halved pixel clock drives `clk_out` |

## Verification
The assertions assume that each high and each low level of `frame_sync` lasts at least two reference cycles, so the two-flop synchroniser sees every pulse. They also assume that reset is released away from a reference clock edge. The stimulus meets the first assumption with pulses 40 ns high and 200 ns low against an 8 ns reference period. It meets the second by releasing reset on a falling reference edge. The pixel clock is held idle through the early tests and is started before the count reaches its target, because the handover needs that clock in order to complete.

// File: rtl/frame_gated_clk_switch.sv
module frame_gated_clk_switch #(
  parameter int SYNC_PULSES = 4
) (
  input  logic ref_clk,
  input  logic cam_pclk,
  input  logic rst_n,
  input  logic frame_sync,
  output logic clk_out,
  output logic locked
);
  localparam int CNT_W = $clog2(SYNC_PULSES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_PULSES - 1);
  localparam logic [CNT_W-1:0] TARGET = CNT_W'(SYNC_PULSES);

  logic fs_meta, fs_sync, fs_prev;
  logic [CNT_W-1:0] pulse_cnt;
  logic switch_req;
  logic fs_rise;

  assign fs_rise = fs_sync & ~fs_prev;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_meta <= 1'b0;
      fs_sync <= 1'b0;
      fs_prev <= 1'b0;
    end else begin
      fs_meta <= frame_sync;
      fs_sync <= fs_meta;
      fs_prev <= fs_sync;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt  <= '0;
      switch_req <= 1'b0;
    end else if (fs_rise && !switch_req) begin
      pulse_cnt <= pulse_cnt + 1'b1;
      if (pulse_cnt == LAST) switch_req <= 1'b1;
    end
  end

  logic half_clk;
  always_ff @(posedge cam_pclk or negedge rst_n) begin
    if (!rst_n) half_clk <= 1'b0;
    else        half_clk <= ~half_clk;
  end

  logic half_en;
  logic ref_s1, ref_s2, ref_en;
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_s1 <= 1'b1;
      ref_s2 <= 1'b1;
    end else begin
      ref_s1 <= ~switch_req;
      ref_s2 <= ref_s1;
    end
  end

  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) ref_en <= 1'b1;
    else        ref_en <= ref_s2 & ~half_en;
  end

  logic half_s1, half_s2;
  always_ff @(posedge half_clk or negedge rst_n) begin
    if (!rst_n) begin
      half_s1 <= 1'b0;
      half_s2 <= 1'b0;
    end else begin
      half_s1 <= switch_req & ~ref_en;
      half_s2 <= half_s1;
    end
  end

  always_ff @(negedge half_clk or negedge rst_n) begin
    if (!rst_n) half_en <= 1'b0;
    else        half_en <= half_en | half_s2;
  end

  assign clk_out = (ref_clk & ref_en) | (half_clk & half_en);
  assign locked  = half_en;

  // R8
  gates_exclusive_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(ref_en && half_en));

  // R8
  count_bound_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pulse_cnt <= TARGET);

  // R4
  req_at_target_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    switch_req |-> pulse_cnt == TARGET);

  // R6
  locked_sticky_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    locked |=> locked);

  // R6
  req_sticky_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    switch_req |=> switch_req && $stable(pulse_cnt));

  // R3
  ref_drop_cause_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(ref_en) |-> switch_req);

  // R7
  half_after_ref_chk: assert property (@(posedge half_clk) disable iff (!rst_n)
    $rose(half_en) |-> !ref_en);
endmodule

// File: tb/tb_frame_gated_clk_switch.sv
`timescale 1ns/1ps
module tb_frame_gated_clk_switch;
  logic ref_clk = 1'b0;
  logic cam_pclk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 1'b0;
  logic clk_out, locked;
  logic pclk_run = 1'b0;

  int checks = 0;
  int fails = 0;
  int short_phases = 0;
  realtime last_t = -1.0;
  realtime min_phase = 1.0e9;

  frame_gated_clk_switch #(.SYNC_PULSES(4)) dut (
    .ref_clk(ref_clk), .cam_pclk(cam_pclk), .rst_n(rst_n),
    .frame_sync(frame_sync), .clk_out(clk_out), .locked(locked)
  );

  always #4 ref_clk = ~ref_clk;

  initial forever begin
    if (pclk_run) #2.5 cam_pclk = ~cam_pclk;
    else #1;
  end

  always @(negedge rst_n) last_t = -1.0;

  always @(clk_out) begin
    if (rst_n) begin
      if (last_t >= 0.0) begin
        if ($realtime - last_t < min_phase) min_phase = $realtime - last_t;
        if ($realtime - last_t < 3.9) short_phases++;
      end
      last_t = $realtime;
    end
  end

  task automatic check(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0.3f expected %0.3f at %0t", req, act, exp, $realtime);
    end
  endtask

  task automatic check_follows_ref(input string req);
    for (int i = 0; i < 4; i++) begin
      @(posedge ref_clk); #2;
      check(clk_out === 1'b1, req, real'(clk_out), 1.0);
      @(negedge ref_clk); #2;
      check(clk_out === 1'b0, req, real'(clk_out), 0.0);
    end
  endtask

  task automatic frame_pulse();
    frame_sync = 1'b1; #40;
    frame_sync = 1'b0; #200;
  endtask

  task automatic measure_period(output realtime p);
    realtime t0;
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); p = $realtime - t0;
  endtask

  task automatic t_reset_state();
    #3;
    check(clk_out === ref_clk, "R1 in reset", real'(clk_out), real'(ref_clk));
    check(locked === 1'b0, "R1 locked in reset", real'(locked), 0.0);
    @(negedge ref_clk); rst_n = 1'b1;
    check_follows_ref("R1");
    check(locked === 1'b0, "R1 locked", real'(locked), 0.0);
  endtask

  task automatic t_idle_pclk();
    frame_pulse();
    check_follows_ref("R2");
  endtask

  task automatic t_below_threshold();
    frame_pulse();
    frame_pulse();
    check(locked === 1'b0, "R3 locked after 3 pulses", real'(locked), 0.0);
    check_follows_ref("R3");
  endtask

  task automatic t_switch();
    pclk_run = 1'b1;
    #100;
    check(locked === 1'b0, "R3 pclk alone", real'(locked), 0.0);
    frame_pulse();
    check(locked === 1'b1, "R4 locked after 4th pulse", real'(locked), 1.0);
  endtask

  task automatic t_half_rate();
    realtime p;
    measure_period(p);
    check(p > 9.99 && p < 10.01, "R5 period", p, 10.0);
    measure_period(p);
    check(p > 9.99 && p < 10.01, "R5 period again", p, 10.0);
  endtask

  task automatic t_hold();
    realtime p;
    frame_pulse();
    frame_pulse();
    frame_sync = 1'b1; #100;
    check(locked === 1'b1, "R6 locked held", real'(locked), 1.0);
    frame_sync = 1'b0; #100;
    measure_period(p);
    check(p > 9.99 && p < 10.01, "R6 period held", p, 10.0);
  endtask

  task automatic t_glitch();
    check(short_phases == 0, "R7 shortest phase", min_phase, 4.0);
  endtask

  task automatic t_reset_again();
    rst_n = 1'b0; #20;
    check(locked === 1'b0, "R9 locked cleared", real'(locked), 0.0);
    @(negedge ref_clk); rst_n = 1'b1;
    check_follows_ref("R9");
    frame_pulse(); frame_pulse(); frame_pulse();
    check(locked === 1'b0, "R9 count restarted", real'(locked), 0.0);
    frame_pulse();
    check(locked === 1'b1, "R9 relock", real'(locked), 1.0);
    check(short_phases == 0, "R7 after relock", min_phase, 4.0);
  endtask

  initial begin
    t_reset_state();
    t_idle_pclk();
    t_below_threshold();
    t_switch();
    t_half_rate();
    t_hold();
    t_glitch();
    t_reset_again();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1600000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule